// File: doc/BRIEF.md
# Predicate Register File with Compare Slots

This block holds a bank of one-bit predicate registers and updates them from several compare slots that can all issue in the same cycle. Each compare takes two signed operands and a relation. It then writes a complementary pair of predicates: one destination receives the outcome and the other receives its inverse. This lets a single test guard both arms of a conditional.

A compare is itself guarded by a qualifying predicate. When that predicate is false, the compare normally leaves its destinations alone. A compare flagged unconditional instead clears both destinations, so a nested conditional behind a false outer test disables both of its inner paths.

Separate read ports return the value of any predicate. Downstream operations use these values to decide whether they take effect or are squashed.

Top module: `pred_cmp_file`

## Requirements
- R1: After reset, predicates 1 to 63 hold 0 and predicate 0 reads 1.
- R2: Predicate 0 always reads 1, and any compare that names it as a destination leaves it at 1.
- R3: The relation code selects 0 = equal, 1 = not equal, 2 = a less than b, 3 = a greater than b, with both operands taken as two's-complement signed values.
- R4: A valid compare whose qualifying predicate is 1 writes its true-destination with the relation outcome and its false-destination with the inverse. The new values appear on the read ports after the next rising clock edge.
- R5: A valid compare that is not unconditional and whose qualifying predicate is 0 changes no predicate.
- R6: A valid unconditional compare whose qualifying predicate is 0 writes 0 to both destinations. When its qualifying predicate is 1, it behaves as in R4.
- R7: Qualifying predicates are read from the state held before the clock edge, so a write to a predicate in one cycle does not affect a compare in that same cycle that is qualified on it.
- R8: All slots can fire in one cycle. When two slots write the same predicate, the higher-numbered slot wins. When one compare names the same predicate as both destinations, the false-destination value wins.
- R9: Each read port returns, combinationally and independently of the others, the current value of the predicate it indexes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | SLOTS | Per-slot compare request |
| cmp_a | input | SLOTS*DW | First operand per slot |
| cmp_b | input | SLOTS*DW | Second operand per slot |
| cmp_rel | input | SLOTS*2 | Relation code per slot |
| cmp_dst_t | input | SLOTS*6 | Destination for the outcome |
| cmp_dst_f | input | SLOTS*6 | Destination for the inverse |
| cmp_qual | input | SLOTS*6 | Qualifying predicate index |
| cmp_unc | input | SLOTS | Unconditional-mode flag |
| rd_idx | input | RPORTS*6 | Read port indices |
| rd_val | output | RPORTS | Read port values |

## Verification
The hardest cases to reach are write collisions: several slots in one cycle targeting the same predicate, or a slot whose qualifier is written by another slot in that same cycle. Predicate indices are random and spread over 64 entries, so such collisions rarely happen by chance.

Directed cycles therefore set up these collisions on purpose. The random phase then narrows the destination and qualifier indices to a handful of low predicates, so that collisions and unconditional clears on live qualifiers occur often. A behavioural model in the bench is compared against every read port on every cycle.

// File: rtl/pred_cmp_file.sv
module pred_cmp_file #(
  parameter int NPRED  = 64,
  parameter int DW     = 64,
  parameter int SLOTS  = 3,
  parameter int RPORTS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SLOTS-1:0]              cmp_valid,
  input  logic [SLOTS*DW-1:0]           cmp_a,
  input  logic [SLOTS*DW-1:0]           cmp_b,
  input  logic [SLOTS*2-1:0]            cmp_rel,
  input  logic [SLOTS*$clog2(NPRED)-1:0] cmp_dst_t,
  input  logic [SLOTS*$clog2(NPRED)-1:0] cmp_dst_f,
  input  logic [SLOTS*$clog2(NPRED)-1:0] cmp_qual,
  input  logic [SLOTS-1:0]              cmp_unc,
  input  logic [RPORTS*$clog2(NPRED)-1:0] rd_idx,
  output logic [RPORTS-1:0]             rd_val
);
  localparam int IW = $clog2(NPRED);

  logic [NPRED-1:0] pf, pf_nxt;
  logic [SLOTS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_rel
      logic signed [DW-1:0] a, b;
      assign a = cmp_a[g*DW +: DW];
      assign b = cmp_b[g*DW +: DW];
      always_comb begin
        unique case (cmp_rel[g*2 +: 2])
          2'd0:    hit[g] = (a == b);
          2'd1:    hit[g] = (a != b);
          2'd2:    hit[g] = (a <  b);
          default: hit[g] = (a >  b);
        endcase
      end
    end
    for (g = 0; g < RPORTS; g++) begin : g_rd
      assign rd_val[g] = pf[rd_idx[g*IW +: IW]];
    end
  endgenerate

  always_comb begin
    pf_nxt = pf;
    for (int s = 0; s < SLOTS; s++) begin
      if (cmp_valid[s]) begin
        if (pf[cmp_qual[s*IW +: IW]]) begin
          pf_nxt[cmp_dst_t[s*IW +: IW]] = hit[s];
          pf_nxt[cmp_dst_f[s*IW +: IW]] = ~hit[s];
        end else if (cmp_unc[s]) begin
          pf_nxt[cmp_dst_t[s*IW +: IW]] = 1'b0;
          pf_nxt[cmp_dst_f[s*IW +: IW]] = 1'b0;
        end
      end
    end
    pf_nxt[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pf <= {{(NPRED-1){1'b0}}, 1'b1};
    else        pf <= pf_nxt;
  end

  logic [IW-1:0] t0, f0, q0;
  logic          solo0;
  assign t0    = cmp_dst_t[IW-1:0];
  assign f0    = cmp_dst_f[IW-1:0];
  assign q0    = cmp_qual[IW-1:0];
  assign solo0 = (cmp_valid == SLOTS'(1));

  a_r2_p0_one: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx[IW-1:0] == '0 |-> rd_val[0]);

  a_r4_pair: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && pf[q0] && t0 != '0 && f0 != '0 && t0 != f0
    |=> pf[$past(t0)] != pf[$past(f0)]);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && !cmp_unc[0] && !pf[q0] |=> $stable(pf));

  a_r6_unc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && cmp_unc[0] && !pf[q0] && t0 != '0 && f0 != '0
    |=> !pf[$past(t0)] && !pf[$past(f0)]);
endmodule

// File: tb/test_pred_cmp_file.sv
`timescale 1ns/1ps
module test_pred_cmp_file;
  localparam int S = 3, R = 3, DW = 64, IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [S-1:0] cmp_valid = '0, cmp_unc = '0;
  logic [S*DW-1:0] cmp_a = '0, cmp_b = '0;
  logic [S*2-1:0] cmp_rel = '0;
  logic [S*IW-1:0] cmp_dst_t = '0, cmp_dst_f = '0, cmp_qual = '0;
  logic [R*IW-1:0] rd_idx = '0;
  logic [R-1:0] rd_val;

  pred_cmp_file i_pred_cmp_file (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit model [64];
  string tag = "R1";

  task automatic put(int s, logic signed [DW-1:0] a, logic signed [DW-1:0] b,
                     int rel, int t, int f, int q, bit unc);
    cmp_valid[s] = 1'b1;
    cmp_a[s*DW +: DW] = a;
    cmp_b[s*DW +: DW] = b;
    cmp_rel[s*2 +: 2] = rel[1:0];
    cmp_dst_t[s*IW +: IW] = t[5:0];
    cmp_dst_f[s*IW +: IW] = f[5:0];
    cmp_qual[s*IW +: IW] = q[5:0];
    cmp_unc[s] = unc;
  endtask

  function automatic bit relate(logic signed [DW-1:0] a, logic signed [DW-1:0] b, int rel);
    case (rel)
      0: return a == b;
      1: return a != b;
      2: return a < b;
      default: return a > b;
    endcase
  endfunction

  task automatic check_reads();
    #1;
    for (int p = 0; p < R; p++) begin
      int k = int'(rd_idx[p*IW +: IW]);
      total++;
      if (rd_val[p] !== model[k]) begin
        bad++;
        $display("FAIL %s: p%0d via port %0d actual=%b expected=%b", tag, k, p, rd_val[p], model[k]);
      end
    end
  endtask

  task automatic step();
    bit old [64];
    check_reads();
    @(posedge clk);
    old = model;
    for (int s = 0; s < S; s++) begin
      if (cmp_valid[s]) begin
        int t = int'(cmp_dst_t[s*IW +: IW]);
        int f = int'(cmp_dst_f[s*IW +: IW]);
        bit h = relate(cmp_a[s*DW +: DW], cmp_b[s*DW +: DW], int'(cmp_rel[s*2 +: 2]));
        if (old[int'(cmp_qual[s*IW +: IW])]) begin
          model[t] = h; model[f] = !h;
        end else if (cmp_unc[s]) begin
          model[t] = 0; model[f] = 0;
        end
      end
    end
    model[0] = 1;
    @(negedge clk);
    cmp_valid = '0;
    cmp_unc = '0;
  endtask

  task automatic sweep(string t);
    tag = t;
    for (int k = 0; k < 64; k += R) begin
      for (int p = 0; p < R; p++) rd_idx[p*IW +: IW] = 6'((k + p) % 64);
      step();
    end
  endtask

  task automatic look(int a, int b, int c);
    rd_idx = {6'(c), 6'(b), 6'(a)};
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) model[k] = 0;
    model[0] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");

    tag = "R3";
    put(0, 64'sd5, 64'sd5, 0, 1, 2, 0, 0);
    put(1, 64'sd5, 64'sd5, 1, 3, 4, 0, 0);
    put(2, -64'sd3, 64'sd2, 2, 5, 6, 0, 0);
    look(1, 3, 5); step();
    put(0, 64'sd7, -64'sd1, 3, 7, 8, 0, 0);
    put(1, 64'sd7, -64'sd1, 2, 9, 10, 0, 0);
    put(2, 64'sd1, 64'sd9, 0, 11, 12, 0, 0);
    look(2, 4, 6); step();
    tag = "R4";
    look(7, 9, 11); step();
    look(8, 10, 12); step();

    tag = "R5";
    put(0, 64'sd1, 64'sd1, 0, 2, 1, 20, 0);
    look(1, 2, 20); step();
    look(1, 2, 20); step();

    tag = "R6";
    put(0, 64'sd1, 64'sd1, 0, 1, 3, 20, 1);
    look(1, 3, 0); step();
    look(1, 3, 0); step();
    put(0, 64'sd1, 64'sd1, 0, 13, 14, 5, 1);
    look(13, 14, 5); step();
    look(13, 14, 5); step();

    tag = "R2";
    put(0, 64'sd1, 64'sd2, 0, 0, 15, 0, 0);
    put(1, 64'sd1, 64'sd2, 1, 16, 0, 20, 1);
    look(0, 15, 16); step();
    look(0, 15, 16); step();

    tag = "R7";
    put(0, 64'sd1, 64'sd2, 0, 21, 22, 0, 0);
    put(1, 64'sd4, 64'sd4, 0, 23, 24, 22, 0);
    look(21, 22, 23); step();
    look(21, 22, 23); step();

    tag = "R8";
    put(0, 64'sd4, 64'sd4, 0, 30, 31, 0, 0);
    put(1, 64'sd4, 64'sd3, 0, 30, 32, 0, 0);
    put(2, 64'sd2, 64'sd2, 0, 33, 33, 0, 0);
    look(30, 31, 32); step();
    look(30, 31, 33); step();
    put(0, 64'sd1, 64'sd1, 0, 34, 35, 0, 0);
    put(2, 64'sd1, 64'sd1, 0, 35, 36, 40, 1);
    look(34, 35, 36); step();
    look(34, 35, 36); step();

    tag = "R9";
    for (int k = 0; k < 200; k++) begin
      rd_idx = R*IW'($urandom);
      for (int s = 0; s < S; s++)
        if ($urandom_range(0, 3) != 0)
          put(s, 64'($signed($urandom_range(0, 6)) - 3), 64'($signed($urandom_range(0, 6)) - 3),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 7)), 1'($urandom));
      step();
    end
    tag = "R8";
    for (int k = 0; k < 1500; k++) begin
      for (int p = 0; p < R; p++) rd_idx[p*IW +: IW] = 6'($urandom_range(0, 5));
      for (int s = 0; s < S; s++)
        if ($urandom_range(0, 4) != 0)
          put(s, 64'($urandom_range(0, 3)) << 62, 64'($urandom_range(0, 3)) << 62,
              int'($urandom_range(0, 3)), int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
              int'($urandom_range(0, 5)), 1'($urandom));
      step();
    end
    sweep("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule